// File: doc/BRIEF.md
# Synchronous Parallel Configuration Byte Loader

This block receives configuration data on a byte-wide port that is clocked by an external configuration clock. Once the ready/init input is high, the block counts rising clock edges. It latches the parallel data bus on the second such edge, and then on every eighth edge after that. Each latch raises a one-cycle acknowledge pulse.

Each latched byte is also forwarded on a serial daisy-chain output, most significant bit first. The forwarding is retimed to the falling clock edge, so the first bit appears half a clock after the parallel load. Shifting runs on every clock whether or not a new byte arrives. A downstream device therefore receives the last byte in full as long as the clock keeps running.

The cadence is held by a three-state machine:
- `ST_IDLE` is the state while init is low or after reset.
- `ST_ARM` counts the lead-in edges before the first capture.
- `ST_STREAM` counts the eight-edge gap between captures.

The named transitions are:
- IDLE→ARM on the first edge with init high.
- ARM→STREAM on the capture edge.
- STREAM→STREAM on each periodic capture.
- any→IDLE whenever an edge sees init low.

Top module: `cfg_byte_loader`

## Requirements
- R1: While `rst_n` is low, `ack` and `ser_out` are 0. After reset is released, the first capture again needs two rising edges with init high.
- R2: The first byte after init rises is captured on the second consecutive rising edge at which `init_rdy` is high.
- R3: Each later capture happens on the eighth rising edge after the previous capture, for as long as `init_rdy` stays high. No capture happens on the edges in between.
- R4: `ack` is 1 for exactly the one clock period that follows a capture edge, and 0 in the period after that.
- R5: A captured byte leaves on `ser_out` most significant bit first. Bit 7 appears at the falling edge right after the capture, and each following falling edge presents the next lower bit, one bit per clock.
- R6: The serial shift continues on every clock regardless of `init_rdy`. Once a byte's eight bits have been sent without a new capture, `ser_out` is 0.
- R7: An edge that sees `init_rdy` low captures nothing, clears the edge count, and leaves `ack` at 0 in the following period. A single-edge init pulse never produces a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Externally supplied configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_rdy | input | 1 | Init/ready level; edges are counted only while it is high |
| data_in | input | 8 | Parallel configuration byte, sampled on capture edges |
| ack | output | 1 | One-cycle acknowledge after each capture |
| ser_out | output | 1 | Serial forward stream, updated on falling edges |

## Verification
The main sequence holds init high over four full capture periods while fresh random bytes are put on the bus every clock. A byte taken one edge early or late therefore shows up as a serial mismatch rather than passing silently. The same sequence then drops init for one edge and raises it again, which separates a counter that truly restarts from one that merely pauses. Directed runs add three more cases:
- a capture followed at once by init low, which tells a free-running shifter from one gated by init;
- alternating one-edge init pulses, which must never reach a capture;
- a reset in mid-stream, which must clear both outputs and restore the two-edge lead-in.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    // Cadence controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // init low or just reset
        ST_ARM    = 2'd1,   // counting lead-in edges before first capture
        ST_STREAM = 2'd2    // counting the gap between periodic captures
    } cad_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfgl_cadence.sv
module cfgl_cadence
    import cfgl_pkg::*;
#(
    parameter int unsigned PERIOD = 8,
    parameter int unsigned LEAD   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_rdy,
    output logic cap_now,
    output logic ack
);

    localparam int unsigned MAXC = max_of(PERIOD, LEAD);
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] ONE       = CW'(1);

    cad_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next-state and capture decode
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cap_now = 1'b0;
        if (!init_rdy) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (LEAD == 1) begin
                        cap_now = 1'b1;
                        state_d = ST_STREAM;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_ARM;
                        cnt_d   = ONE;
                    end
                end
                ST_ARM: begin
                    if (cnt_q == LEAD_LAST) begin
                        cap_now = 1'b1;
                        state_d = ST_STREAM;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                ST_STREAM: begin
                    if (cnt_q == GAP_LAST) begin
                        cap_now = 1'b1;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack <= 1'b0;
        end else begin
            ack <= cap_now;
        end
    end

endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] par_in,
    output logic              msb
);

    logic [DATA_W-1:0] sh_q;

    // Parallel load on capture, otherwise shift left with zero fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= par_in;
        end else begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[DATA_W-1];

endmodule

// File: rtl/cfgl_fall_stage.sv
module cfgl_fall_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // Half-cycle retime: the forward bit changes on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PERIOD = 8,
    parameter int unsigned LEAD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_rdy,
    input  logic [DATA_W-1:0] data_in,
    output logic              ack,
    output logic              ser_out
);

    logic cap_now;
    logic sh_msb;

    cfgl_cadence #(
        .PERIOD (PERIOD),
        .LEAD   (LEAD)
    ) cadence_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_rdy (init_rdy),
        .cap_now  (cap_now),
        .ack      (ack)
    );

    cfgl_shifter #(
        .DATA_W (DATA_W)
    ) shifter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cap_now),
        .par_in (data_in),
        .msb    (sh_msb)
    );

    cfgl_fall_stage fall_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sh_msb),
        .q     (ser_out)
    );

endmodule

// File: rtl/cfg_byte_loader_chk.sv
module cfg_byte_loader_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PERIOD = 8,
    parameter int unsigned LEAD   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_rdy,
    input logic [DATA_W-1:0] data_in,
    input logic              ack,
    input logic              ser_out
);

    int unsigned run_cnt;   // consecutive edges seen with init high
    logic [7:0]  since_ack; // edges since the last observed ack, saturating

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= 0;
        end else if (init_rdy) begin
            run_cnt <= run_cnt + 1;
        end else begin
            run_cnt <= 0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_ack <= 8'hFF;
        end else if (ack) begin
            since_ack <= 8'd0;
        end else if (since_ack != 8'hFF) begin
            since_ack <= since_ack + 8'd1;
        end
    end

    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == LEAD) |-> ack); // R2

    AST_CAPTURE_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt > LEAD) |-> (ack == (((run_cnt - LEAD) % PERIOD) == 0))); // R3

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R4

    AST_SER_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (ser_out == $past(data_in[DATA_W-1]))); // R5

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && since_ack >= 8'(DATA_W - 1)) |-> !ser_out); // R6

    AST_NO_ACK_WITHOUT_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        !init_rdy |=> !ack); // R7

endmodule

bind cfg_byte_loader cfg_byte_loader_chk #(
    .DATA_W (DATA_W),
    .PERIOD (PERIOD),
    .LEAD   (LEAD)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_rdy (init_rdy),
    .data_in  (data_in),
    .ack      (ack),
    .ser_out  (ser_out)
);

// File: tb/cfg_byte_loader_tb_top.sv
module cfg_byte_loader_tb_top;

    localparam time CLK_PERIOD = 125ns;
    localparam int  NSTEP      = 40;

    // {init for this step's rising edge, expected ack sampled before it}
    localparam logic [1:0] VEC [0:NSTEP-1] = '{
        2'b00, 2'b10, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b10,
        2'b10, 2'b10, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b10,
        2'b10, 2'b10, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b10,
        2'b10, 2'b10, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b10,
        2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b11, 2'b10, 2'b10
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_rdy = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       ack;
    logic       ser_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_byte_loader dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_rdy (init_rdy),
        .data_in  (data_in),
        .ack      (ack),
        .ser_out  (ser_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Move to the sample point: after a falling edge, before the next rising edge
    task automatic advance();
        @(negedge clk);
        #(CLK_PERIOD/4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] exp_byte;
        logic [7:0] prev_data;
        logic [7:0] byte_b;
        int         bits_left;
        string      tag;

        exp_byte  = 8'h00;
        prev_data = 8'h00;
        bits_left = 0;

        // Reset state (R1)
        repeat (3) advance();
        chk("R1 ack in reset", {7'd0, ack}, 8'h00);
        chk("R1 ser_out in reset", {7'd0, ser_out}, 8'h00);
        rst_n = 1'b1;

        // Vector walk: cadence, ack shape, serial stream, restart
        for (int k = 0; k < NSTEP; k++) begin
            advance();
            if (VEC[k][0]) tag = (k == 3 || k == 37) ? "R2 first capture" : "R3 periodic capture";
            else if (k > 0 && VEC[k-1][0]) tag = "R4 ack width";
            else if (k == 35 || k == 36) tag = "R7 init low restart";
            else tag = "R3 no capture between";
            chk(tag, {7'd0, ack}, {7'd0, VEC[k][0]});

            if (VEC[k][0]) begin
                exp_byte  = prev_data;
                bits_left = 8;
            end
            if (bits_left > 0) begin
                chk("R5 serial bit", {7'd0, ser_out}, {7'd0, exp_byte[bits_left-1]});
                bits_left--;
            end else begin
                chk("R6 zero fill", {7'd0, ser_out}, 8'h00);
            end

            init_rdy  = VEC[k][1];
            data_in   = 8'($urandom_range(0, 255));
            prev_data = data_in;
        end

        // Flush with init low, then capture one byte and drop init at once (R6)
        init_rdy = 1'b0;
        repeat (10) advance();
        chk("R6 idle flushed", {7'd0, ser_out}, 8'h00);
        init_rdy = 1'b1;
        data_in  = 8'h11;
        advance();
        byte_b  = 8'hB5;
        data_in = byte_b;
        advance();
        init_rdy = 1'b0;
        data_in  = 8'hFF;
        chk("R2 capture before flush", {7'd0, ack}, 8'h01);
        for (int b = 7; b >= 0; b--) begin
            chk("R6 shift continues with init low", {7'd0, ser_out}, {7'd0, byte_b[b]});
            advance();
            chk("R7 no ack with init low", {7'd0, ack}, 8'h00);
        end
        chk("R6 zero after last bit", {7'd0, ser_out}, 8'h00);

        // Single-edge init pulses never capture (R7)
        for (int p = 0; p < 6; p++) begin
            init_rdy = 1'b1;
            data_in  = 8'(8'hC3 + p);
            advance();
            chk("R7 pulse high no ack", {7'd0, ack}, 8'h00);
            init_rdy = 1'b0;
            advance();
            chk("R7 pulse low no ack", {7'd0, ack}, 8'h00);
        end

        // Reset in mid-stream, then lead-in restarts (R1)
        init_rdy = 1'b1;
        data_in  = 8'h5A;
        advance();
        data_in = 8'hF0;
        advance();
        chk("R2 capture before reset", {7'd0, ack}, 8'h01);
        chk("R5 msb before reset", {7'd0, ser_out}, 8'h01);
        rst_n = 1'b0;
        #1;
        chk("R1 ack cleared by reset", {7'd0, ack}, 8'h00);
        chk("R1 ser_out cleared by reset", {7'd0, ser_out}, 8'h00);
        advance();
        rst_n   = 1'b1;
        data_in = 8'h3C;
        advance();
        chk("R1 one edge after reset no ack", {7'd0, ack}, 8'h00);
        data_in = 8'h81;
        advance();
        chk("R1 lead-in restored ack", {7'd0, ack}, 8'h01);
        chk("R1 lead-in restored msb", {7'd0, ser_out}, 8'h01);
        init_rdy = 1'b0;
        advance();
        chk("R5 second bit after reset", {7'd0, ser_out}, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule